// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Loader

This block steers one DMA channel along a chain of descriptors kept in memory. Software loads the channel's first descriptor by hand into four channel registers: source address, destination address, next pointer and a control word. It then sets the enable bit. The block hands the register contents to a separate transfer engine through a start/done handshake, so the first packet runs with no memory read at all.

Each time a packet completes, the block looks at the next pointer. A zero pointer ends the chain: the enable clears and a one-cycle completion pulse is raised. Any other pointer makes the block read a four-word descriptor through a simple request/valid memory read port, overwrite the channel registers with it, and start the next packet. A read error during a fetch stops the chain with an error flag, and no further packet is started.

The registers can be read at any time through a select-driven read port, so software can see the descriptor in use.

The controller walks through these states:
- IDLE
- XFER, which pulses start
- WAIT, which waits for done
- FETCH, which reads four words
- STOP, which ends the chain normally
- ABORT, which ends it on a read error

The transitions are:
- IDLE→XFER on enable.
- XFER→WAIT always.
- WAIT→STOP on done when the pointer is zero.
- WAIT→FETCH on done otherwise.
- FETCH→XFER when the fourth word arrives.
- FETCH→ABORT on a read error.
- STOP→IDLE and ABORT→IDLE always.

Top module: `sg_chain_loader`

## Requirements
- R1: After reset the enable bit, the error flag and all four channel registers read zero, and `xfer_start`, `mem_req` and `done_irq` are low.
- R2: Writing 1 to bit 0 of the status register (select code 4) while the enable is clear sets the enable. The block then gives one `xfer_start` pulse carrying the software-written source, destination and control values, with no memory read before that first packet.
- R3: When a packet finishes and the next pointer is nonzero, the block makes four reads at pointer+0, +4, +8 and +12, in that order. The words land in source, destination, next pointer and control, in that order.
- R4: The channel registers are replaced only after the packet's done has been seen and all four words have arrived. The following packet starts with the new values, and reading select codes 0 to 3 (source, destination, next, control) returns them.
- R5: When a packet finishes and pointer bits [31:2] are zero, `done_irq` is high for exactly one cycle and the enable reads 0 from the next cycle on.
- R6: Bits [1:0] of the next pointer are ignored, both for the end-of-chain test and for the fetch address.
- R7: While the enable is set, writes to the four channel registers and to the status register have no effect.
- R8: A read error on any descriptor word ends the chain. The enable clears, the error flag (status bit 1) sets, no `done_irq` is raised, no further packet starts, and the channel registers keep their previous values.
- R9: Starting a new chain clears the error flag.
- R10: `xfer_start` is never high on two consecutive cycles, and `mem_req` is only high while the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Write select: 0 src, 1 dst, 2 next, 3 ctrl, 4 status |
| reg_wr_data | input | W | Register write data |
| reg_rd_sel | input | 3 | Read select, same codes |
| reg_rd_data | output | W | Selected register; status is {err, enable} in bits [1:0] |
| xfer_start | output | 1 | One-cycle packet start to the engine |
| xfer_src | output | W | Packet source address |
| xfer_dst | output | W | Packet destination address |
| xfer_ctl | output | W | Packet control word |
| xfer_done | input | 1 | Engine packet-complete pulse |
| mem_req | output | 1 | Descriptor read request, held until a response |
| mem_addr | output | W | Descriptor word address |
| mem_rdata | input | W | Read data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rerr | input | 1 | Read response carries an error |
| done_irq | output | 1 | Chain completion pulse |
| chain_err | output | 1 | Error flag |

## Verification
The block is tried with several input patterns:
- A one-descriptor chain shows that the first packet comes from the registers with no fetch.
- A three-descriptor chain, whose middle pointer has its low bits set, tells apart word ordering, address stepping, masking of the pointer bits and the moment the registers are reloaded.
- A bare pointer of 3 separates a masked end test from a raw compare.
- Writes issued while busy show whether the busy guard holds.
- An error injected on the third descriptor word tells a staged commit apart from in-place overwriting.
- A restart afterwards shows that the error flag clears.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
    localparam int DESC_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_WAIT,
        ST_FETCH,
        ST_STOP,
        ST_ABORT
    } sgl_state_e;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_NXT  = 3'd2;
    localparam logic [2:0] SEL_CTL  = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;
endpackage

// File: rtl/sgl_chan_regs.sv
module sgl_chan_regs
    import sgl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [W-1:0]            wr_data,
    input  logic [2:0]              rd_sel,
    output logic [W-1:0]            rd_data,
    input  logic                    load,
    input  logic [DESC_WORDS*W-1:0] load_words,
    input  logic                    stop_done,
    input  logic                    abort,
    output logic [W-1:0]            src,
    output logic [W-1:0]            dst,
    output logic [W-1:0]            nxt,
    output logic [W-1:0]            ctl,
    output logic                    en,
    output logic                    err
);
    logic [W-1:0] chan_q [DESC_WORDS];
    logic         en_q;
    logic         err_q;
    logic         start_wr;

    // software writes only land while the channel is idle
    assign start_wr = wr_en && !en_q && (wr_sel == SEL_STAT) && wr_data[0];

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_q[g] <= '0;
            end else if (load) begin
                chan_q[g] <= load_words[g*W +: W];
            end else if (wr_en && !en_q && (wr_sel == 3'(g))) begin
                chan_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (stop_done || abort) begin
                en_q <= 1'b0;
            end else if (start_wr) begin
                en_q <= 1'b1;
            end
            if (abort) begin
                err_q <= 1'b1;
            end else if (start_wr) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_SRC:  rd_data = chan_q[0];
            SEL_DST:  rd_data = chan_q[1];
            SEL_NXT:  rd_data = chan_q[2];
            SEL_CTL:  rd_data = chan_q[3];
            SEL_STAT: rd_data = {{(W-2){1'b0}}, err_q, en_q};
            default:  rd_data = '0;
        endcase
    end

    assign src = chan_q[0];
    assign dst = chan_q[1];
    assign nxt = chan_q[2];
    assign ctl = chan_q[3];
    assign en  = en_q;
    assign err = err_q;
endmodule

// File: rtl/sgl_desc_fetch.sv
module sgl_desc_fetch
    import sgl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic [W-3:0]            base_hi,
    output logic                    mem_req,
    output logic [W-1:0]            mem_addr,
    input  logic [W-1:0]            mem_rdata,
    input  logic                    mem_rvalid,
    input  logic                    mem_rerr,
    output logic [DESC_WORDS*W-1:0] words,
    output logic                    fetch_ok,
    output logic                    fetch_err
);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             good_beat;
    logic [W-1:0]     stage_q [DESC_WORDS-1];

    assign good_beat = active && mem_rvalid && !mem_rerr;
    assign mem_req   = active;
    assign mem_addr  = {base_hi, 2'b00} + (W'(idx_q) << 2);
    assign fetch_ok  = good_beat && (idx_q == LAST_IDX);
    assign fetch_err = active && mem_rvalid && mem_rerr;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            idx_q <= '0;
        end else if (good_beat) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // all but the last word are staged; the last is used straight from the bus
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_stage
        if (g < DESC_WORDS - 1) begin : g_hold
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (good_beat && (idx_q == IDX_W'(g))) begin
                    stage_q[g] <= mem_rdata;
                end
            end
            assign words[g*W +: W] = stage_q[g];
        end else begin : g_bypass
            assign words[g*W +: W] = mem_rdata;
        end
    end
endmodule

// File: rtl/sgl_ctrl_fsm.sv
module sgl_ctrl_fsm
    import sgl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-3:0] nxt_hi,
    input  logic         xfer_done,
    input  logic         fetch_ok,
    input  logic         fetch_err,
    output logic         xfer_start,
    output logic         fetch_active,
    output logic         load,
    output logic         stop_done,
    output logic         abort,
    output sgl_state_e   state_o
);
    sgl_state_e state_q;
    sgl_state_e state_d;
    logic       chain_end;

    assign chain_end = (nxt_hi == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_XFER;
            ST_XFER:  state_d = ST_WAIT;
            ST_WAIT:  if (xfer_done) state_d = chain_end ? ST_STOP : ST_FETCH;
            ST_FETCH: begin
                if (fetch_err) begin
                    state_d = ST_ABORT;
                end else if (fetch_ok) begin
                    state_d = ST_XFER;
                end
            end
            ST_STOP:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        xfer_start   = 1'b0;
        fetch_active = 1'b0;
        load         = 1'b0;
        stop_done    = 1'b0;
        abort        = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_XFER:  xfer_start = 1'b1;
            ST_WAIT:  ;
            ST_FETCH: begin
                fetch_active = 1'b1;
                load         = fetch_ok && !fetch_err;
            end
            ST_STOP:  stop_done = 1'b1;
            ST_ABORT: abort = 1'b1;
            default:  ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/sg_chain_loader.sv
module sg_chain_loader
    import sgl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr_en,
    input  logic [2:0]   reg_wr_sel,
    input  logic [W-1:0] reg_wr_data,
    input  logic [2:0]   reg_rd_sel,
    output logic [W-1:0] reg_rd_data,
    output logic         xfer_start,
    output logic [W-1:0] xfer_src,
    output logic [W-1:0] xfer_dst,
    output logic [W-1:0] xfer_ctl,
    input  logic         xfer_done,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_rvalid,
    input  logic         mem_rerr,
    output logic         done_irq,
    output logic         chain_err
);
    logic [W-1:0]            nxt;
    logic                    chan_en;
    logic                    load;
    logic                    stop_done;
    logic                    abort;
    logic                    fetch_active;
    logic                    fetch_ok;
    logic                    fetch_err;
    logic [DESC_WORDS*W-1:0] words;
    sgl_state_e              fsm_state;

    sgl_chan_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_data    (reg_wr_data),
        .rd_sel     (reg_rd_sel),
        .rd_data    (reg_rd_data),
        .load       (load),
        .load_words (words),
        .stop_done  (stop_done),
        .abort      (abort),
        .src        (xfer_src),
        .dst        (xfer_dst),
        .nxt        (nxt),
        .ctl        (xfer_ctl),
        .en         (chan_en),
        .err        (chain_err)
    );

    sgl_desc_fetch #(.W(W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (fetch_active),
        .base_hi    (nxt[W-1:2]),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .words      (words),
        .fetch_ok   (fetch_ok),
        .fetch_err  (fetch_err)
    );

    sgl_ctrl_fsm #(.W(W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (chan_en),
        .nxt_hi       (nxt[W-1:2]),
        .xfer_done    (xfer_done),
        .fetch_ok     (fetch_ok),
        .fetch_err    (fetch_err),
        .xfer_start   (xfer_start),
        .fetch_active (fetch_active),
        .load         (load),
        .stop_done    (stop_done),
        .abort        (abort),
        .state_o      (fsm_state)
    );

    assign done_irq = stop_done;
endmodule

// File: rtl/sgl_chk.sv
module sgl_chk
    import sgl_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         xfer_start,
    input logic [W-1:0] xfer_src,
    input logic [W-1:0] xfer_dst,
    input logic [W-1:0] xfer_ctl,
    input logic         mem_req,
    input logic         done_irq,
    input logic         chain_err,
    input logic         chan_en,
    input sgl_state_e   state
);
    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_req_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> chan_en);

    assert_start_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> chan_en);

    assert_irq_clears_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> (!chan_en && !done_irq));

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_err) |-> (!chan_en && !done_irq && !xfer_start));

    // R4: the channel registers do not move while a packet is outstanding
    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state) == ST_WAIT)
            |-> ($stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_ctl)));
endmodule

bind sg_chain_loader sgl_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst),
    .xfer_ctl   (xfer_ctl),
    .mem_req    (mem_req),
    .done_irq   (done_irq),
    .chain_err  (chain_err),
    .chan_en    (chan_en),
    .state      (fsm_state)
);

// File: tb/sim_sg_chain_loader.sv
`timescale 1ns/1ps
module sim_sg_chain_loader;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [2:0]   reg_wr_sel = '0;
    logic [W-1:0] reg_wr_data = '0;
    logic [2:0]   reg_rd_sel = '0;
    logic [W-1:0] reg_rd_data;
    logic         xfer_start;
    logic [W-1:0] xfer_src, xfer_dst, xfer_ctl;
    logic         xfer_done;
    logic         mem_req;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_rdata;
    logic         mem_rvalid;
    logic         mem_rerr;
    logic         done_irq;
    logic         chain_err;

    always #2.5 clk = ~clk;

    sg_chain_loader #(.W(W)) u0 (.*);

    // memory, engine and monitors
    logic [W-1:0] mem [64];
    logic         err_en = 1'b0;
    logic [W-1:0] err_addr = '0;
    int           cyc = 0;
    int           start_cnt = 0, rd_cnt = 0, irq_cnt = 0, done_cnt = 0;
    logic [W-1:0] log_src [32], log_dst [32], log_ctl [32], log_addr [32];
    int           log_rd_cyc [32], log_done_cyc [32];
    int           cd = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
            mem_rdata  <= '0;
            xfer_done  <= 1'b0;
            cd         <= 0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rerr   <= mem_req && !mem_rvalid && err_en && (mem_addr == err_addr);
            mem_rdata  <= mem[mem_addr[7:2]];
            if (mem_req && !mem_rvalid) begin
                log_addr[rd_cnt % 32]   <= mem_addr;
                log_rd_cyc[rd_cnt % 32] <= cyc;
                rd_cnt <= rd_cnt + 1;
            end
            if (xfer_start) begin
                log_src[start_cnt % 32] <= xfer_src;
                log_dst[start_cnt % 32] <= xfer_dst;
                log_ctl[start_cnt % 32] <= xfer_ctl;
                start_cnt <= start_cnt + 1;
                cd <= 4;
            end else if (cd > 0) begin
                cd <= cd - 1;
            end
            xfer_done <= (cd == 1);
            if (xfer_done) begin
                log_done_cyc[done_cnt % 32] <= cyc;
                done_cnt <= done_cnt + 1;
            end
            if (done_irq) irq_cnt <= irq_cnt + 1;
        end
    end

    int n_checks = 0, n_errs = 0;
    int wd_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [W-1:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [W-1:0] data);
        @(negedge clk);
        reg_rd_sel = sel;
        #1 data = reg_rd_data;
    endtask

    task automatic start_chain(input logic [W-1:0] s, input logic [W-1:0] d,
                               input logic [W-1:0] n, input logic [W-1:0] c);
        wr(3'd0, s);
        wr(3'd1, d);
        wr(3'd2, n);
        wr(3'd3, c);
        wr(3'd4, 1);
    endtask

    task automatic wait_idle();
        logic [W-1:0] st;
        for (int i = 0; i < 400; i++) begin
            rd(3'd4, st);
            if (st[0] == 1'b0) return;
        end
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            check(v == '0, "R1 register after reset", v, '0);
        end
        check({mem_req, xfer_start, done_irq} == 3'b000, "R1 outputs after reset",
              W'({mem_req, xfer_start, done_irq}), '0);
    endtask

    task automatic t_single();
        int s0 = start_cnt, r0 = rd_cnt, i0 = irq_cnt;
        logic [W-1:0] v;
        start_chain(32'h1000, 32'h2000, 32'h0, 32'hA5);
        wait_idle();
        check(start_cnt - s0 == 1, "R2 one packet", W'(start_cnt - s0), 1);
        check(log_src[s0 % 32] == 32'h1000, "R2 first src", log_src[s0 % 32], 32'h1000);
        check(log_dst[s0 % 32] == 32'h2000, "R2 first dst", log_dst[s0 % 32], 32'h2000);
        check(log_ctl[s0 % 32] == 32'hA5, "R2 first ctl", log_ctl[s0 % 32], 32'hA5);
        check(rd_cnt == r0, "R2 no fetch", W'(rd_cnt - r0), 0);
        check(irq_cnt - i0 == 1, "R5 single irq", W'(irq_cnt - i0), 1);
        rd(3'd4, v);
        check(v == 0, "R5 enable cleared", v, 0);
    endtask

    task automatic t_chain();
        int s0 = start_cnt, r0 = rd_cnt, i0 = irq_cnt, d0 = done_cnt;
        logic [W-1:0] v;
        logic [W-1:0] exp_addr [8] = '{32'h40, 32'h44, 32'h48, 32'h4C,
                                        32'h80, 32'h84, 32'h88, 32'h8C};
        mem[16] = 32'h1100; mem[17] = 32'h2100; mem[18] = 32'h83; mem[19] = 32'h11;
        mem[32] = 32'h1200; mem[33] = 32'h2200; mem[34] = 32'h0;  mem[35] = 32'h22;
        start_chain(32'h1000, 32'h2000, 32'h40, 32'h10);
        wait_idle();
        check(start_cnt - s0 == 3, "R3 three packets", W'(start_cnt - s0), 3);
        check(rd_cnt - r0 == 8, "R3 eight reads", W'(rd_cnt - r0), 8);
        for (int k = 0; k < 8; k++)
            check(log_addr[(r0 + k) % 32] == exp_addr[k], "R3 R6 fetch address",
                  log_addr[(r0 + k) % 32], exp_addr[k]);
        check(log_src[(s0 + 1) % 32] == 32'h1100, "R3 second src", log_src[(s0 + 1) % 32], 32'h1100);
        check(log_dst[(s0 + 1) % 32] == 32'h2100, "R3 second dst", log_dst[(s0 + 1) % 32], 32'h2100);
        check(log_ctl[(s0 + 1) % 32] == 32'h11, "R3 second ctl", log_ctl[(s0 + 1) % 32], 32'h11);
        check(log_src[(s0 + 2) % 32] == 32'h1200, "R4 third src", log_src[(s0 + 2) % 32], 32'h1200);
        check(log_rd_cyc[r0 % 32] > log_done_cyc[d0 % 32], "R4 fetch after done",
              W'(log_rd_cyc[r0 % 32]), W'(log_done_cyc[d0 % 32] + 1));
        rd(3'd0, v); check(v == 32'h1200, "R4 src readback", v, 32'h1200);
        rd(3'd1, v); check(v == 32'h2200, "R4 dst readback", v, 32'h2200);
        rd(3'd2, v); check(v == 32'h0, "R4 next readback", v, 32'h0);
        rd(3'd3, v); check(v == 32'h22, "R4 ctl readback", v, 32'h22);
        check(irq_cnt - i0 == 1, "R5 irq at chain end", W'(irq_cnt - i0), 1);
    endtask

    task automatic t_lowbits();
        int s0 = start_cnt, r0 = rd_cnt, i0 = irq_cnt;
        start_chain(32'h1500, 32'h2500, 32'h3, 32'h5);
        wait_idle();
        check(start_cnt - s0 == 1, "R6 pointer 3 ends chain", W'(start_cnt - s0), 1);
        check(rd_cnt == r0, "R6 no fetch for pointer 3", W'(rd_cnt - r0), 0);
        check(irq_cnt - i0 == 1, "R6 irq for pointer 3", W'(irq_cnt - i0), 1);
    endtask

    task automatic t_busy();
        int s0 = start_cnt, r0 = rd_cnt;
        logic [W-1:0] v;
        start_chain(32'h3000, 32'h4000, 32'h0, 32'h33);
        wr(3'd0, 32'hDEAD);
        wr(3'd2, 32'h40);
        wr(3'd4, 1);
        wait_idle();
        check(start_cnt - s0 == 1, "R7 busy writes add no packet", W'(start_cnt - s0), 1);
        check(log_src[s0 % 32] == 32'h3000, "R7 src kept", log_src[s0 % 32], 32'h3000);
        check(rd_cnt == r0, "R7 next write ignored", W'(rd_cnt - r0), 0);
        rd(3'd0, v); check(v == 32'h3000, "R7 src readback", v, 32'h3000);
        rd(3'd2, v); check(v == 32'h0, "R7 next readback", v, 32'h0);
    endtask

    task automatic t_error();
        int s0 = start_cnt, r0 = rd_cnt, i0 = irq_cnt;
        logic [W-1:0] v;
        err_en = 1'b1;
        err_addr = 32'h48;
        start_chain(32'h5000, 32'h6000, 32'h40, 32'h55);
        wait_idle();
        err_en = 1'b0;
        check(start_cnt - s0 == 1, "R8 no packet after error", W'(start_cnt - s0), 1);
        check(rd_cnt - r0 == 3, "R8 fetch stops at bad word", W'(rd_cnt - r0), 3);
        check(irq_cnt == i0, "R8 no irq on abort", W'(irq_cnt - i0), 0);
        rd(3'd4, v); check(v == 32'h2, "R8 status err set en clear", v, 32'h2);
        check(chain_err == 1'b1, "R8 error output", W'(chain_err), 1);
        rd(3'd0, v); check(v == 32'h5000, "R8 src unchanged", v, 32'h5000);
        rd(3'd2, v); check(v == 32'h40, "R8 next unchanged", v, 32'h40);
    endtask

    task automatic t_restart();
        logic [W-1:0] v;
        start_chain(32'h7000, 32'h8000, 32'h0, 32'h77);
        rd(3'd4, v);
        check(v[1] == 1'b0, "R9 error cleared by start", v, 32'h1);
        wait_idle();
        check(chain_err == 1'b0, "R9 error stays clear", W'(chain_err), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_chain();
        t_lowbits();
        t_busy();
        t_error();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs + wd_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            wd_fail = 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_errs + wd_fail);
            $finish;
        end
    end
endmodule